// File: doc/BRIEF.md
# Flash Bank Image Validator

This block judges whether a non-volatile configuration image held in one flash bank is intact. The image enters as a byte stream, one byte per cycle in which `in_valid` is high. `in_first` marks offset 0 and `in_last` marks the final byte. While the bytes go by, the block does four things:

- It checks the fixed marker byte at the start of the image.
- It forms an 8-bit header sum whose carries are wrapped back into the low byte.
- It runs a two-half modulo-65521 checksum over the body.
- It captures the stored body checksum and the stored generation count.

One cycle after the final byte it reports the verdict, the generation and both computed sums.

Two copies of the image are kept, and a writer always fills the older copy. In dual mode the caller streams bank 0 and then bank 1. The block then names the bank that holds the newer valid image. A copy that fails any check counts as generation zero. Ties go to bank 0.

Top module: `nvram_image_validator`

## Requirements
- R1: `res_valid` is high for exactly one cycle, the cycle after the byte that carries `in_last` is accepted. The byte that carries `in_first` is offset 0, and later accepted bytes take consecutive offsets.
- R2: The byte at offset 0 must equal 0x5A. Otherwise `res_ok` is 0 and `res_gen` is 0.
- R3: `calc_hdr_sum` is formed in two steps. First, the 16-bit sum of offset 0 and offsets 2 to 15 is taken. Second, that sum is folded by adding its high byte to its low byte until it fits in 8 bits. It must equal the byte at offset 1, or the image is invalid.
- R4: `calc_body_sum` has two halves, kept modulo 65521 after every byte. The low half starts at 1 and the high half starts at 0. For each byte from offset 0x14 to the last, the byte is added to the low half, and then the low half is added to the high half. `calc_body_sum` is high half << 16 | low half, and each half stays below 65521.
- R5: The stored body checksum is offsets 0x10 to 0x13, big-endian. A mismatch with `calc_body_sum` makes the image invalid.
- R6: When all checks pass, `res_ok` is 1 and `res_gen` is the big-endian word at offsets 0x14 to 0x17.
- R7: With `dual_mode` high, results alternate between banks, and `res_bank` gives 0 then 1. `pick_valid` pulses one cycle after the bank-1 result. `bank_sel` is 1 only when the bank-0 generation is strictly less than the bank-1 generation. `bank_sel` changes only on that pulse.
- R8: Cycles with `in_valid` low are ignored, whatever `in_data`, `in_first` and `in_last` carry during them.
- R9: With `dual_mode` low, `res_bank` is 0 and `pick_valid` never asserts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dual_mode | input | 1 | Stream two banks and choose one |
| in_valid | input | 1 | A byte is offered this cycle |
| in_first | input | 1 | This byte is offset 0 |
| in_last | input | 1 | This byte ends the bank |
| in_data | input | 8 | Image byte |
| res_valid | output | 1 | Verdict pulse |
| res_ok | output | 1 | All checks passed |
| res_gen | output | 32 | Generation, zero if invalid |
| res_bank | output | 1 | Bank the verdict belongs to |
| calc_hdr_sum | output | 8 | Folded header sum computed |
| calc_body_sum | output | 32 | Body checksum computed |
| pick_valid | output | 1 | Bank choice pulse |
| bank_sel | output | 1 | Chosen bank |

## Verification
The hardest situation to reach is an image that fails exactly one check while the other two still pass. Such an image shows that each check really gates the verdict. The stimulus builds every image from scratch and computes its header and body sums. It then spoils just one item: the marker byte (with the header sum recomputed to match), the stored header byte, or the stored body word. The bank choice is driven in the same way. One dual pair has equal generations, and others have one bank invalid, so its generation collapses to zero. An all-0xFF image pushes both halves of the body sum through many modulo wraps.

// File: rtl/nvv_pkg.sv
package nvv_pkg;

   localparam int unsigned HALF_W = 16;

   // Wrap the carries of a 16-bit sum back into its low byte until it fits.
   function automatic logic [7:0] fold16(input logic [15:0] s);
      logic [15:0] t;
      t = {8'h00, s[7:0]} + {8'h00, s[15:8]};
      t = {8'h00, t[7:0]} + {8'h00, t[15:8]};
      return t[7:0];
   endfunction

endpackage

// File: rtl/nvv_field_cap.sv
module nvv_field_cap #(
   parameter int IW     = 14,
   parameter int OFFSET = 0,
   parameter int NBYTES = 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  take,
   input  logic [IW-1:0]         idx,
   input  logic [7:0]            data,
   output logic [8*NBYTES-1:0]   value
);
   localparam logic [IW-1:0] LO = IW'(OFFSET);
   localparam logic [IW-1:0] HI = IW'(OFFSET + NBYTES);

   logic hit;
   assign hit = take && (idx >= LO) && (idx < HI);

   generate
      if (NBYTES == 1) begin : g_single
         always_ff @(posedge clk) begin
            if (!rst_n)   value <= '0;
            else if (hit) value <= data;
         end
      end else begin : g_multi
         // earlier bytes shift toward the top: big-endian assembly
         always_ff @(posedge clk) begin
            if (!rst_n)   value <= '0;
            else if (hit) value <= {value[8*NBYTES-9:0], data};
         end
      end
   endgenerate
endmodule

// File: rtl/nvv_hdr_sum.sv
module nvv_hdr_sum
   import nvv_pkg::*;
#(
   parameter int IW      = 14,
   parameter int HDR_END = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          take,
   input  logic [IW-1:0] idx,
   input  logic [7:0]    data,
   output logic [7:0]    folded
);
   localparam logic [IW-1:0] SKIP = IW'(1);
   localparam logic [IW-1:0] ENDX = IW'(HDR_END);

   logic [15:0] sum_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sum_q <= '0;
      end else if (take) begin
         if (idx == '0)
            sum_q <= {8'h00, data};
         else if (idx > SKIP && idx < ENDX)
            sum_q <= sum_q + {8'h00, data};
      end
   end

   assign folded = fold16(sum_q);
endmodule

// File: rtl/nvv_body_sum.sv
module nvv_body_sum #(
   parameter int IW         = 14,
   parameter int BODY_START = 20,
   parameter int MODULUS    = 65521
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          take,
   input  logic [IW-1:0] idx,
   input  logic [7:0]    data,
   output logic [15:0]   low,
   output logic [15:0]   high
);
   localparam logic [IW-1:0] FROM = IW'(BODY_START);
   localparam logic [16:0]   MODV = 17'(MODULUS);

   logic [15:0] low_q, high_q, low_n, high_n;
   logic [16:0] lsum, hsum;

   always_comb begin
      lsum   = {1'b0, low_q} + {9'b0, data};
      low_n  = 16'((lsum >= MODV) ? lsum - MODV : lsum);
      hsum   = {1'b0, high_q} + {1'b0, low_n};
      high_n = 16'((hsum >= MODV) ? hsum - MODV : hsum);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         low_q  <= 16'd1;
         high_q <= '0;
      end else if (take) begin
         if (idx == '0) begin
            low_q  <= 16'd1;
            high_q <= '0;
         end else if (idx >= FROM) begin
            low_q  <= low_n;
            high_q <= high_n;
         end
      end
   end

   assign low  = low_q;
   assign high = high_q;
endmodule

// File: rtl/nvv_bank_pick.sv
module nvv_bank_pick (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        dual_mode,
   input  logic        res_valid,
   input  logic [31:0] res_gen,
   output logic        cur_bank,
   output logic        pick_valid,
   output logic        bank_sel
);
   logic        bank_q, pick_q, sel_q;
   logic [31:0] gen0_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bank_q <= 1'b0;
         pick_q <= 1'b0;
         sel_q  <= 1'b0;
         gen0_q <= '0;
      end else begin
         pick_q <= 1'b0;
         if (!dual_mode) begin
            bank_q <= 1'b0;
         end else if (res_valid) begin
            if (!bank_q) begin
               gen0_q <= res_gen;
               bank_q <= 1'b1;
            end else begin
               pick_q <= 1'b1;
               sel_q  <= (gen0_q < res_gen);
               bank_q <= 1'b0;
            end
         end
      end
   end

   assign cur_bank   = bank_q;
   assign pick_valid = pick_q;
   assign bank_sel   = sel_q;
endmodule

// File: rtl/nvram_image_validator.sv
module nvram_image_validator
   import nvv_pkg::*;
#(
   parameter int          BANK_BYTES = 8192,
   parameter int          HDR_END    = 16,
   parameter int          SUM_AT     = 16,
   parameter int          GEN_AT     = 20,
   parameter int          BODY_START = 20,
   parameter int          MODULUS    = 65521,
   parameter logic [7:0]  SIG_VALUE  = 8'h5A
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        dual_mode,
   input  logic        in_valid,
   input  logic        in_first,
   input  logic        in_last,
   input  logic [7:0]  in_data,
   output logic        res_valid,
   output logic        res_ok,
   output logic [31:0] res_gen,
   output logic        res_bank,
   output logic [7:0]  calc_hdr_sum,
   output logic [31:0] calc_body_sum,
   output logic        pick_valid,
   output logic        bank_sel
);
   localparam int IW = $clog2(BANK_BYTES) + 1;

   // elaboration-time parameter checks
   if (BODY_START < 1 || BODY_START >= BANK_BYTES) begin : g_bad_body
      $error("BODY_START must lie inside the bank and after offset 0");
   end
   if (MODULUS < 256 || MODULUS > 65535) begin : g_bad_mod
      $error("MODULUS must fit in 16 bits and exceed a byte");
   end
   if (GEN_AT + 4 > BANK_BYTES || SUM_AT + 4 > BANK_BYTES || HDR_END > BANK_BYTES) begin : g_bad_fields
      $error("header fields must fit inside the bank");
   end

   logic          take;
   logic [IW-1:0] cnt_q, idx;
   logic          done_q;

   assign take = in_valid;
   assign idx  = in_first ? '0 : cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= take && in_last;
         if (take) cnt_q <= idx + 1'b1;
      end
   end

   logic [7:0]  sig_byte, stored_hdr, hdr_fold;
   logic [31:0] stored_sum, stored_gen;
   logic [15:0] body_low, body_high;

   nvv_field_cap #(.IW(IW), .OFFSET(0), .NBYTES(1)) u_sig (
      .clk(clk), .rst_n(rst_n), .take(take), .idx(idx), .data(in_data), .value(sig_byte));
   nvv_field_cap #(.IW(IW), .OFFSET(1), .NBYTES(1)) u_hck (
      .clk(clk), .rst_n(rst_n), .take(take), .idx(idx), .data(in_data), .value(stored_hdr));
   nvv_field_cap #(.IW(IW), .OFFSET(SUM_AT), .NBYTES(4)) u_sum (
      .clk(clk), .rst_n(rst_n), .take(take), .idx(idx), .data(in_data), .value(stored_sum));
   nvv_field_cap #(.IW(IW), .OFFSET(GEN_AT), .NBYTES(4)) u_gen (
      .clk(clk), .rst_n(rst_n), .take(take), .idx(idx), .data(in_data), .value(stored_gen));

   nvv_hdr_sum #(.IW(IW), .HDR_END(HDR_END)) u_hdr (
      .clk(clk), .rst_n(rst_n), .take(take), .idx(idx), .data(in_data), .folded(hdr_fold));

   nvv_body_sum #(.IW(IW), .BODY_START(BODY_START), .MODULUS(MODULUS)) u_body (
      .clk(clk), .rst_n(rst_n), .take(take), .idx(idx), .data(in_data),
      .low(body_low), .high(body_high));

   logic all_good;
   assign all_good = (sig_byte == SIG_VALUE)
                  && (hdr_fold == stored_hdr)
                  && ({body_high, body_low} == stored_sum);

   assign res_valid     = done_q;
   assign res_ok        = done_q && all_good;
   assign res_gen       = (done_q && all_good) ? stored_gen : '0;
   assign calc_hdr_sum  = hdr_fold;
   assign calc_body_sum = {body_high, body_low};

   nvv_bank_pick u_pick (
      .clk(clk), .rst_n(rst_n), .dual_mode(dual_mode),
      .res_valid(done_q), .res_gen(res_gen),
      .cur_bank(res_bank), .pick_valid(pick_valid), .bank_sel(bank_sel));
endmodule

// File: rtl/nvv_chk.sv
module nvv_chk #(
   parameter int MODULUS = 65521
) (
   input logic        clk,
   input logic        rst_n,
   input logic        dual_mode,
   input logic        in_valid,
   input logic        in_last,
   input logic        res_valid,
   input logic        res_bank,
   input logic [31:0] calc_body_sum,
   input logic        pick_valid,
   input logic        bank_sel
);
   localparam logic [15:0] MODV = 16'(MODULUS);

   assert_pulse_after_last_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_last) |=> res_valid);
   assert_pulse_has_cause_R1: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> $past(in_valid && in_last));
   assert_low_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
      calc_body_sum[15:0] < MODV);
   assert_high_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
      calc_body_sum[31:16] < MODV);
   assert_pick_follows_bank1_R7: assert property (@(posedge clk) disable iff (!rst_n)
      pick_valid |-> $past(res_valid && res_bank));
   assert_sel_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !pick_valid |-> $stable(bank_sel));
   assert_no_pick_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
      pick_valid |-> $past(dual_mode));
endmodule

bind nvram_image_validator nvv_chk #(.MODULUS(MODULUS)) u_chk (
   .clk(clk), .rst_n(rst_n), .dual_mode(dual_mode), .in_valid(in_valid),
   .in_last(in_last), .res_valid(res_valid), .res_bank(res_bank),
   .calc_body_sum(calc_body_sum), .pick_valid(pick_valid), .bank_sel(bank_sel));

// File: tb/nvram_image_validator_tb.sv
module nvram_image_validator_tb;
   localparam int BANK = 8192;

   logic clk = 1'b0, rst_n = 1'b0, dual_mode = 1'b0;
   logic in_valid = 1'b0, in_first = 1'b0, in_last = 1'b0;
   logic [7:0] in_data = 8'h00;
   logic res_valid, res_ok, res_bank, pick_valid, bank_sel;
   logic [31:0] res_gen, calc_body_sum;
   logic [7:0] calc_hdr_sum;

   always #10 clk = ~clk;

   nvram_image_validator u_dut (
      .clk(clk), .rst_n(rst_n), .dual_mode(dual_mode), .in_valid(in_valid),
      .in_first(in_first), .in_last(in_last), .in_data(in_data),
      .res_valid(res_valid), .res_ok(res_ok), .res_gen(res_gen), .res_bank(res_bank),
      .calc_hdr_sum(calc_hdr_sum), .calc_body_sum(calc_body_sum),
      .pick_valid(pick_valid), .bank_sel(bank_sel));

   typedef struct {
      logic ok; logic [31:0] gen; logic [7:0] hs; logic [31:0] bs; logic bank;
   } exp_t;

   exp_t exp_q[$];
   logic pick_q[$];
   logic [7:0] img [BANK];
   int total = 0, bad = 0;

   task automatic chk(input bit cond, input string req, input logic [31:0] act, input logic [31:0] exv);
      total++;
      if (!cond) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exv);
      end
   endtask

   // kind: 0 good, 1 bad marker, 2 bad header byte, 3 bad stored body word, 4 all-0xFF good
   task automatic build(input int seed, input logic [31:0] gen, input int kind,
                        input logic bank, output logic [31:0] eff_gen);
      logic [15:0] s;
      int lo, hi;
      exp_t e;
      for (int i = 0; i < BANK; i++)
         img[i] = (kind == 4) ? 8'hFF : 8'((i * seed) + (i >> 5) * 7 + seed);
      img[0] = (kind == 1) ? 8'h5B : 8'h5A;
      img[20] = gen[31:24]; img[21] = gen[23:16]; img[22] = gen[15:8]; img[23] = gen[7:0];
      s = {8'h00, img[0]};
      for (int i = 2; i < 16; i++) s = s + {8'h00, img[i]};
      while (s > 16'h00FF) s = {8'h00, s[7:0]} + {8'h00, s[15:8]};
      e.hs = s[7:0];
      img[1] = (kind == 2) ? (s[7:0] ^ 8'h01) : s[7:0];
      lo = 1; hi = 0;
      for (int i = 20; i < BANK; i++) begin
         lo = (lo + int'(img[i])) % 65521;
         hi = (hi + lo) % 65521;
      end
      e.bs = {hi[15:0], lo[15:0]};
      begin
         logic [31:0] st;
         st = (kind == 3) ? (e.bs ^ 32'h0000_0001) : e.bs;
         img[16] = st[31:24]; img[17] = st[23:16]; img[18] = st[15:8]; img[19] = st[7:0];
      end
      e.ok   = (kind == 0 || kind == 4);
      e.gen  = e.ok ? gen : 32'h0;
      e.bank = bank;
      eff_gen = e.gen;
      exp_q.push_back(e);
   endtask

   task automatic stream(input bit gaps);
      for (int i = 0; i < BANK; i++) begin
         @(posedge clk); #2;
         if (gaps && (i % 997) == 500) begin
            // R8: junk on an idle cycle must change nothing
            in_valid = 1'b0; in_data = 8'hA5; in_first = 1'b1; in_last = 1'b1;
            @(posedge clk); #2;
         end
         in_valid = 1'b1; in_data = img[i]; in_first = (i == 0); in_last = (i == BANK - 1);
      end
      @(posedge clk); #2;
      in_valid = 1'b0; in_first = 1'b0; in_last = 1'b0;
      @(negedge clk);
      chk(res_valid == 1'b1, "R1 pulse", {31'b0, res_valid}, 32'h1);
      @(negedge clk);
      chk(res_valid == 1'b0, "R1 single cycle", {31'b0, res_valid}, 32'h0);
   endtask

   task automatic single(input int seed, input logic [31:0] gen, input int kind, input bit gaps);
      logic [31:0] g;
      dual_mode = 1'b0;
      build(seed, gen, kind, 1'b0, g);
      stream(gaps);
   endtask

   task automatic pair(input int s0, input logic [31:0] g0, input int k0,
                       input int s1, input logic [31:0] g1, input int k1);
      logic [31:0] e0, e1;
      dual_mode = 1'b1;
      build(s0, g0, k0, 1'b0, e0);
      stream(1'b0);
      build(s1, g1, k1, 1'b1, e1);
      pick_q.push_back(e0 < e1);   // R7 strict comparison
      stream(1'b0);
      repeat (3) @(negedge clk);
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && res_valid) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, "R1 unexpected result", 32'h1, 32'h0);
         end else begin
            exp_t e;
            e = exp_q.pop_front();
            chk(res_ok == e.ok, "R2/R5 ok", {31'b0, res_ok}, {31'b0, e.ok});
            chk(res_gen == e.gen, "R6 gen", res_gen, e.gen);
            chk(calc_hdr_sum == e.hs, "R3 hdr", {24'b0, calc_hdr_sum}, {24'b0, e.hs});
            chk(calc_body_sum == e.bs, "R4 body", calc_body_sum, e.bs);
            chk(res_bank == e.bank, "R7/R9 bank", {31'b0, res_bank}, {31'b0, e.bank});
         end
      end
      if (rst_n && pick_valid) begin
         if (pick_q.size() == 0) begin
            chk(1'b0, "R9 pick in single mode", 32'h1, 32'h0);
         end else begin
            logic ps;
            ps = pick_q.pop_front();
            chk(bank_sel == ps, "R7 sel", {31'b0, bank_sel}, {31'b0, ps});
         end
      end
   end

   task automatic summary;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      bad++;
      $display("FAIL R1 watchdog act=%0d exp=%0d", 1, 0);
      summary();
   end

   initial begin
      repeat (4) @(posedge clk);
      #2 rst_n = 1'b1;
      @(negedge clk);
      chk(res_valid == 1'b0, "R1 reset", {31'b0, res_valid}, 32'h0);
      chk(pick_valid == 1'b0, "R7 reset", {31'b0, pick_valid}, 32'h0);
      chk(bank_sel == 1'b0, "R7 reset sel", {31'b0, bank_sel}, 32'h0);

      single(3,  32'h0000_0011, 0, 1'b0);  // R6 good image
      single(5,  32'h0000_0022, 1, 1'b0);  // R2 marker wrong
      single(7,  32'h0000_0033, 2, 1'b0);  // R3 header byte wrong
      single(11, 32'h0000_0044, 3, 1'b0);  // R5 stored body word wrong
      single(0,  32'h1234_5678, 4, 1'b0);  // R4 all-0xFF, many wraps
      single(13, 32'h0000_0055, 0, 1'b1);  // R8 idle cycles with junk

      pair(17, 32'd5, 0, 19, 32'd9, 0);    // R7 bank 1 newer
      pair(23, 32'd9, 0, 29, 32'd5, 0);    // R7 bank 0 newer
      pair(31, 32'd7, 0, 37, 32'd7, 0);    // R7 tie keeps bank 0
      pair(41, 32'd3, 0, 43, 32'd8, 3);    // R7 invalid bank 1 counts as zero
      pair(47, 32'd6, 2, 53, 32'd2, 0);    // R7 invalid bank 0 counts as zero

      repeat (5) @(negedge clk);
      chk(exp_q.size() == 0, "R1 missing results", exp_q.size(), 32'h0);
      chk(pick_q.size() == 0, "R7 missing picks", pick_q.size(), 32'h0);
      summary();
   end
endmodule